// File: doc/BRIEF.md
# Quadrature Mixer and Fifth-Order CIC Decimator

This block is the front end of a digital downconverter for an RF signal that has been undersampled by a 16-bit ADC. A phase accumulator advances by a programmable tuning word on every clock. Its upper bits address a quarter-wave sine table, which gives a cosine and a sine of the same phase. Each incoming sample is multiplied by both values to form the in-phase (I) and quadrature (Q) streams. Each product is rounded to an 18-bit mixer word.

Each stream feeds a fifth-order cascaded integrator-comb decimator. The integrators run on every clock and are 48 bits wide, wrapping modulo 2^48. The comb section runs once per output. The decimation ratio R is programmable from 2 to 64. A new ratio takes effect at the next output boundary, and the comb delays are cleared at that point. Each output word is the comb result rounded to its top 24 bits, and each output pair comes with a one-cycle valid strobe. The tuning word can be rewritten at any time and is used from the following clock.

Top module: `nco_cic_ddc`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `out_valid` = 0, `i_out` = 0 and `q_out` = 0.
- R2: `out_valid` is high for exactly one cycle, and consecutive pulses are spaced by the active ratio R in clock cycles.
- R3: With tuning word 0 after reset, cosine = +32767 and sine = 0. For a constant input x, the steady I output is round(M·R^5 / 2^24) and Q is 0, where M = floor((x·32767 + 2^13) / 2^14).
- R4: The output rounding is half-up on the 2^24 scale. With x = 128 and R = 8 the steady I output is 1, and with x = −128 it is 0.
- R5: The table gives exact values at the quarter points (0, ±32767). A tuning word of 2^30 (quarter turn per sample) with R a multiple of 4, or 2^31 (half turn) with R even, gives a steady output of the sum of the mixer words over R samples times R^4, rounded to the 2^24 scale.
- R6: A ratio written with `ratio_load` does not alter the interval in progress. The interval that ends at the next output is still the old R, and all later intervals use the new R.
- R7: The output at the switching boundary still carries the old steady value. From the sixth output after it onward, the outputs equal the steady value for the new R.
- R8: Full-scale constant inputs (+32767, −32768) at R = 64 give the exact steady output over a run long enough for the integrators to wrap past 2^48 many times.
- R9: Ratio values below 2 are taken as 2, and values above 64 are taken as 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one ADC sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_in | input | 16 | Signed ADC sample |
| ftw_in | input | 32 | Tuning word (phase increment per clock, full turn = 2^32) |
| ftw_load | input | 1 | Capture `ftw_in` at this edge |
| ratio_in | input | 7 | Requested decimation ratio |
| ratio_load | input | 1 | Capture `ratio_in` as pending ratio |
| i_out | output | 24 | Signed decimated in-phase word |
| q_out | output | 24 | Signed decimated quadrature word |
| out_valid | output | 1 | One-cycle strobe marking a new I/Q pair |

## Verification
Constant inputs at zero tuning, with positive and negative signs and several ratios, set the gain law R^5 and the mixer scaling apart from sign handling. The ±128 pair at R = 8 lands exactly on a half LSB, so it separates round-half-up from truncation and from symmetric rounding. Full-scale inputs at R = 64 for over a thousand cycles show that the wrapping integrators still give the exact result. Quarter-turn and half-turn tuning words should null both paths, so they expose errors in the table folding, the quadrant sign or the cosine offset. Ratio switches show when the interval changes, and the output sequence after a switch shows when the cleared comb has settled.

// File: rtl/nco_cic_ddc.sv
module nco_cic_ddc #(
  parameter int DW    = 16,
  parameter int PW    = 32,
  parameter int LW    = 8,
  parameter int AW    = 16,
  parameter int MW    = 18,
  parameter int ACC_W = 48,
  parameter int OW    = 24,
  parameter int ORD   = 5,
  parameter int RMAX  = 64,
  parameter int R_RST = 8,
  parameter int RW    = $clog2(RMAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] adc_in,
  input  logic [PW-1:0]        ftw_in,
  input  logic                 ftw_load,
  input  logic [RW-1:0]        ratio_in,
  input  logic                 ratio_load,
  output logic signed [OW-1:0] i_out,
  output logic signed [OW-1:0] q_out,
  output logic                 out_valid
);
  localparam int QN   = 1 << LW;
  localparam int PIDX = LW + 2;
  localparam int PRW  = DW + AW;
  localparam int SH   = PRW - MW;
  localparam int OSH  = ACC_W - OW;
  localparam logic signed [PRW-1:0]   MIX_HALF = PRW'(1) <<< (SH - 1);
  localparam logic signed [ACC_W-1:0] OUT_HALF = ACC_W'(1) <<< (OSH - 1);

  logic signed [AW-1:0] qtab [0:QN];
  for (genvar k = 0; k <= QN; k++) begin : g_tab
    localparam real ANG = 3.14159265358979 * k / (2.0 * QN);
    assign qtab[k] = AW'($rtoi($sin(ANG) * ((2.0 ** (AW - 1)) - 1.0) + 0.5));
  end

  logic [PW-1:0] phase, ftw_q;
  logic [PIDX-1:0] pidx [2];
  logic signed [AW-1:0] wave [2];

  assign pidx[0] = phase[PW-1 -: PIDX] + PIDX'(QN);
  assign pidx[1] = phase[PW-1 -: PIDX];

  for (genvar g = 0; g < 2; g++) begin : g_lut
    logic [LW:0] ti;
    logic signed [AW-1:0] mag;
    assign ti      = pidx[g][LW] ? (LW+1)'(QN) - {1'b0, pidx[g][LW-1:0]}
                                 : {1'b0, pidx[g][LW-1:0]};
    assign mag     = qtab[ti];
    assign wave[g] = pidx[g][LW+1] ? -mag : mag;
  end

  logic signed [DW-1:0]    x_r;
  logic signed [AW-1:0]    w_r   [2];
  logic signed [PRW-1:0]   prod  [2];
  logic signed [MW-1:0]    mix   [2];
  logic signed [ACC_W-1:0] integ [2][ORD];
  logic signed [ACC_W-1:0] dly   [2][ORD];
  logic signed [ACC_W-1:0] cv    [2][ORD+1];

  for (genvar g = 0; g < 2; g++) begin : g_path
    assign mix[g]   = MW'((prod[g] + MIX_HALF) >>> SH);
    assign cv[g][0] = integ[g][ORD-1];
    for (genvar k = 0; k < ORD; k++) begin : g_comb
      assign cv[g][k+1] = cv[g][k] - dly[g][k];
    end
  end

  logic [RW-1:0] cnt, r_act, r_pend, r_clamp;
  logic pend, bnd;

  assign r_clamp = (ratio_in < RW'(2))    ? RW'(2)    :
                   (ratio_in > RW'(RMAX)) ? RW'(RMAX) : ratio_in;
  assign bnd = (cnt == r_act - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= '0;
      ftw_q     <= '0;
      x_r       <= '0;
      cnt       <= '0;
      r_act     <= RW'(R_RST);
      r_pend    <= RW'(R_RST);
      pend      <= 1'b0;
      i_out     <= '0;
      q_out     <= '0;
      out_valid <= 1'b0;
      for (int g = 0; g < 2; g++) begin
        w_r[g]  <= '0;
        prod[g] <= '0;
        for (int k = 0; k < ORD; k++) begin
          integ[g][k] <= '0;
          dly[g][k]   <= '0;
        end
      end
    end else begin
      phase <= phase + ftw_q;
      if (ftw_load) ftw_q <= ftw_in;
      x_r <= adc_in;
      for (int g = 0; g < 2; g++) begin
        w_r[g]      <= wave[g];
        prod[g]     <= PRW'(x_r) * PRW'(w_r[g]);
        integ[g][0] <= integ[g][0] + ACC_W'(mix[g]);
        for (int k = 1; k < ORD; k++)
          integ[g][k] <= integ[g][k] + integ[g][k-1];
      end
      out_valid <= bnd;
      if (bnd) begin
        cnt   <= '0;
        i_out <= OW'((cv[0][ORD] + OUT_HALF) >>> OSH);
        q_out <= OW'((cv[1][ORD] + OUT_HALF) >>> OSH);
        for (int g = 0; g < 2; g++)
          for (int k = 0; k < ORD; k++)
            dly[g][k] <= pend ? '0 : cv[g][k];
        if (pend) begin
          r_act <= r_pend;
          pend  <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (ratio_load) begin
        r_pend <= r_clamp;
        pend   <= 1'b1;
      end
    end
  end
endmodule

module nco_cic_ddc_chk #(
  parameter int RW   = 7,
  parameter int RMAX = 64,
  parameter int OW   = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 out_valid,
  input logic signed [OW-1:0] i_out,
  input logic signed [OW-1:0] q_out,
  input logic [RW-1:0]        r_act
);
  logic [RW:0]   gap;
  logic [RW-1:0] r_hold;
  logic          have, was_rst;

  always_ff @(posedge clk) begin
    was_rst <= !rst_n;
    if (!rst_n) begin
      gap    <= '0;
      r_hold <= '0;
      have   <= 1'b0;
    end else if (out_valid) begin
      gap    <= (RW+1)'(1);
      r_hold <= r_act;
      have   <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  always @(posedge clk) begin
    if (was_rst) begin
      // R1
      reset_quiet_chk: assert (!out_valid && i_out == '0 && q_out == '0);
    end
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R2
  valid_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && have) |-> (gap == {1'b0, r_hold}));

  // R9
  ratio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_act >= RW'(2)) && (r_act <= RW'(RMAX)));

  // R6
  ratio_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(r_act) |-> out_valid);
endmodule

bind nco_cic_ddc nco_cic_ddc_chk #(.RW(RW), .RMAX(RMAX), .OW(OW)) chk_i (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid),
  .i_out(i_out), .q_out(q_out), .r_act(r_act)
);

// File: tb/nco_cic_ddc_tb_top.sv
module nco_cic_ddc_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst_n;
  logic signed [15:0] adc_in;
  logic [31:0]        ftw_in;
  logic               ftw_load;
  logic [6:0]         ratio_in;
  logic               ratio_load;
  logic signed [23:0] i_out, q_out;
  logic               out_valid;

  nco_cic_ddc dut_i (
    .clk(clk), .rst_n(rst_n), .adc_in(adc_in), .ftw_in(ftw_in),
    .ftw_load(ftw_load), .ratio_in(ratio_in), .ratio_load(ratio_load),
    .i_out(i_out), .q_out(q_out), .out_valid(out_valid)
  );

  // {x[31:16], ratio[15:8], tuning mode[7:0]}; mode 0: word 0, 1: 2^30, 2: 2^31
  localparam logic [31:0] VEC [9] = '{
    32'h03E8_0800, 32'hFC18_0800, 32'h0080_0800, 32'hFF80_0800,
    32'h7FFF_4000, 32'h8000_4000, 32'h4E20_1001, 32'h1388_0202,
    32'h0007_0300
  };

  int errs = 0, checks = 0;
  bit done = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint mixv(input longint p);
    return (p + 64'sd8192) >>> 14;
  endfunction

  function automatic longint expect_out(input int x, input int r, input int mode, input bit qp);
    longint cs[4], sn[4], s, tot;
    int per;
    cs = '{32767, 0, -32767, 0};
    sn = '{0, 32767, 0, -32767};
    per = (mode == 0) ? 1 : (mode == 1) ? 4 : 2;
    if (mode == 2) begin
      cs = '{32767, -32767, 0, 0};
      sn = '{0, 0, 0, 0};
    end
    s = 0;
    for (int k = 0; k < per; k++) s += mixv(longint'(x) * (qp ? sn[k] : cs[k]));
    tot = s * (r / per) * r * r * r * r;
    return (tot + 64'sd8388608) >>> 24;
  endfunction

  task automatic wait_valid(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!out_valid && n < 1000);
  endtask

  task automatic skip(input int k);
    int n;
    for (int i = 0; i < k; i++) wait_valid(n);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; ftw_load = 1'b0; ratio_load = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load_ratio(input int val);
    ratio_in = 7'(val); ratio_load = 1'b1;
    @(negedge clk);
    ratio_load = 1'b0;
  endtask

  task automatic load_ratio_at_valid(input int val, output int n);
    ratio_in = 7'(val); ratio_load = 1'b1;
    @(negedge clk);
    ratio_load = 1'b0;
    n = 1;
    while (!out_valid) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    rst_n = 1'b0; adc_in = '0; ftw_in = '0; ftw_load = 1'b0;
    ratio_in = '0; ratio_load = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid", longint'(out_valid), 0);
    check("R1 i_out", longint'(i_out), 0);
    check("R1 q_out", longint'(q_out), 0);

    for (int v = 0; v < 9; v++) begin
      int x, r, m;
      string tag;
      x = int'($signed(VEC[v][31:16]));
      r = int'(VEC[v][15:8]);
      m = int'(VEC[v][7:0]);
      tag = (v < 2 || v == 8) ? "R3" : (v < 4) ? "R4" : (v < 6) ? "R8" : "R5";
      adc_in = 16'(x);
      do_reset();
      ftw_in = (m == 0) ? 32'h0 : (m == 1) ? 32'h4000_0000 : 32'h8000_0000;
      ftw_load = 1'b1;
      load_ratio(r);
      ftw_load = 1'b0;
      skip(20);
      check({tag, " I"}, longint'(i_out), expect_out(x, r, m, 1'b0));
      check({tag, " Q"}, longint'(q_out), expect_out(x, r, m, 1'b1));
    end

    adc_in = 16'sd1000;
    do_reset();
    load_ratio(5);
    skip(4);
    wait_valid(n);
    check("R2 period 5", n, 5);

    do_reset();
    load_ratio(0);
    skip(4);
    wait_valid(n);
    check("R9 clamp low", n, 2);
    load_ratio(100);
    skip(4);
    wait_valid(n);
    check("R9 clamp high", n, 64);

    do_reset();
    skip(3);
    load_ratio_at_valid(12, n);
    check("R6 old interval", n, 8);
    wait_valid(n);
    check("R6 new interval", n, 12);

    adc_in = 16'sd1000;
    do_reset();
    skip(20);
    load_ratio_at_valid(16, n);
    check("R7 switch output", longint'(i_out), expect_out(1000, 8, 0, 1'b0));
    skip(5);
    wait_valid(n);
    check("R7 sixth output", longint'(i_out), expect_out(1000, 16, 0, 1'b0));
    wait_valid(n);
    check("R7 seventh output", longint'(i_out), expect_out(1000, 16, 0, 1'b0));
    check("R7 q zero", longint'(q_out), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule